// File: doc/BRIEF.md
# Regenerator Section Receive Framer

This block takes a byte-aligned synchronous-hierarchy line stream, one byte per clock, and finds the frame boundary in it. It searches for the framing pattern and confirms it before declaring lock. It then tracks row and column for every byte and removes the frame-synchronous scrambling. It also checks the regenerator-section parity byte against a bit-interleaved parity that it accumulates over the previous frame exactly as that frame arrived on the line.

Downstream logic receives the descrambled bytes with their row and column, a start-of-frame strobe and a lock flag. For each frame whose parity can be trusted, it also receives a parity-check strobe with the number of disagreeing parity bits and an errored-block pulse. The interleave factor, frame geometry and loss threshold are parameters. The bench uses the single-interleave geometry of 9 rows by 270 columns.

Top module: `rs_sink_framer`

## Requirements
- R1: After reset `frm_locked`, `frm_sof`, `b1_chk` and `b1_blk_err` are all 0.
- R2: A framing hit is three bytes 0xF6 followed immediately by three bytes 0x28, and the last 0x28 is taken as row 0, column 3·NCH+2. In the hunt state a hit at any byte offset sets the frame phase. If a second hit arrives exactly one frame later at that phase, `frm_locked` rises. Lock can also be regained at a new phase after the stream has shifted.
- R3: If the framing bytes at the expected position do not match while a phase is only tentative, the framer returns to hunting. One later hit then does not give lock; two spaced hits are needed again.
- R4: While locked, `frm_locked` falls only after 4 consecutive frames miss the framing bytes at the expected position. A single good frame clears the miss count.
- R5: Outputs are registered with one cycle of latency. `frm_row` and `frm_col` give the position of the byte on `frm_data`. `frm_sof` pulses together with the byte at row 0, column 0 when locked.
- R6: Row 0 bytes pass through unchanged. All other bytes are XORed with the keystream of the generator x^7+x^6+1, taken MSB first. The keystream is reloaded with all ones at row 1, column 0, so its first key byte is 0xFE.
- R7: The expected parity is the XOR of all line bytes of the previous frame, before descrambling. It is compared with the descrambled byte at row 1, column 0. `b1_chk` pulses one cycle after that byte, and `b1_bits` gives the number of differing bits (0 to 8).
- R8: `b1_blk_err` pulses together with `b1_chk` exactly when `b1_bits` is non-zero.
- R9: No parity check is reported unless the framer was locked for the whole previous frame and is still locked. This covers the first frame after lock and every frame while out of lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Byte clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_byte | input | 8 | Received line byte, one per clock |
| frm_locked | output | 1 | Frame lock (in-frame) flag |
| frm_sof | output | 1 | Start-of-frame strobe with row 0, column 0 |
| frm_row | output | ROW_W | Row of the byte on frm_data |
| frm_col | output | COL_W | Column of the byte on frm_data |
| frm_data | output | 8 | Descrambled byte |
| b1_chk | output | 1 | Parity check performed this cycle |
| b1_bits | output | 4 | Count of parity bits in error |
| b1_blk_err | output | 1 | Errored-block pulse |

## Verification
Clean frames show that the descrambled payload and positions are correct and that the parity count is zero. A line error on the parity byte itself is reported in the same frame and again in the next one. A payload line error is reported only in the following frame. Together these show that the parity is taken over the scrambled line bytes of the preceding frame. Sequences of frames with damaged framing bytes separate the miss counter from its reset, and a tentative phase from a confirmed one. A burst of filler bytes shifts the frame phase and shows that the framer locks again at the new position.

// File: rtl/rsf_pkg.sv
package rsf_pkg;

  typedef enum logic [1:0] {
    FR_HUNT    = 2'd0,
    FR_PRESYNC = 2'd1,
    FR_SYNC    = 2'd2
  } fr_state_t;

  // number of set bits in a byte
  function automatic logic [3:0] ones8(input logic [7:0] v);
    logic [3:0] n;
    n = '0;
    for (int i = 0; i < 8; i++) n = n + {3'b000, v[i]};
    return n;
  endfunction

endpackage

// File: rtl/rsf_fa_detect.sv
module rsf_fa_detect #(
  parameter int unsigned PAT_HALF = 3,
  parameter logic [7:0]  A1_BYTE  = 8'hF6,
  parameter logic [7:0]  A2_BYTE  = 8'h28
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] din,
  output logic       hit
);
  localparam int unsigned PAT_LEN = 2 * PAT_HALF;
  localparam int unsigned HIST    = PAT_LEN - 1;

  logic [7:0]         hist [HIST];
  logic [PAT_LEN-1:0] eq;

  // history of the previous bytes, hist[0] newest
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HIST; i++) hist[i] <= '0;
    end else begin
      hist[0] <= din;
      for (int i = 1; i < HIST; i++) hist[i] <= hist[i-1];
    end
  end

  for (genvar k = 0; k < HIST; k++) begin : g_cmp
    localparam int unsigned IDX = PAT_LEN - 2 - k;
    assign eq[k] = (hist[k] == ((IDX < PAT_HALF) ? A1_BYTE : A2_BYTE));
  end
  assign eq[HIST] = (din == A2_BYTE);
  assign hit      = &eq;

  AST_HIT_PRIOR_A2: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(din) == A2_BYTE);  // R2

endmodule

// File: rtl/rsf_align.sv
module rsf_align
  import rsf_pkg::*;
#(
  parameter int unsigned ROWS       = 9,
  parameter int unsigned COLS       = 270,
  parameter int unsigned FA_COL     = 5,
  parameter int unsigned MISS_LIMIT = 4,
  localparam int unsigned ROW_W     = $clog2(ROWS),
  localparam int unsigned COL_W     = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             fa_hit,
  output fr_state_t        state,
  output logic [ROW_W-1:0] row,
  output logic [COL_W-1:0] col
);
  localparam int unsigned MISS_W = $clog2(MISS_LIMIT + 1);
  localparam logic [COL_W-1:0]  COL_LAST  = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0]  ROW_LAST  = ROW_W'(ROWS - 1);
  localparam logic [COL_W-1:0]  COL_FA    = COL_W'(FA_COL);
  localparam logic [COL_W-1:0]  COL_AFTER = COL_W'(FA_COL + 1);
  localparam logic [MISS_W-1:0] MISS_TOP  = MISS_W'(MISS_LIMIT - 1);

  logic [MISS_W-1:0] miss;
  logic [ROW_W-1:0]  row_inc;
  logic [COL_W-1:0]  col_inc;
  logic              at_fa;

  assign at_fa = (row == '0) && (col == COL_FA);

  always_comb begin
    if (col == COL_LAST) begin
      col_inc = '0;
      row_inc = (row == ROW_LAST) ? '0 : row + 1'b1;
    end else begin
      col_inc = col + 1'b1;
      row_inc = row;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= FR_HUNT;
      row   <= '0;
      col   <= '0;
      miss  <= '0;
    end else begin
      row <= row_inc;
      col <= col_inc;
      unique case (state)
        FR_HUNT: begin
          miss <= '0;
          if (fa_hit) begin
            state <= FR_PRESYNC;
            row   <= '0;
            col   <= COL_AFTER;
          end
        end
        FR_PRESYNC: begin
          if (at_fa) state <= fa_hit ? FR_SYNC : FR_HUNT;
        end
        FR_SYNC: begin
          if (at_fa) begin
            if (fa_hit) begin
              miss <= '0;
            end else if (miss == MISS_TOP) begin
              miss  <= '0;
              state <= FR_HUNT;
            end else begin
              miss <= miss + 1'b1;
            end
          end
        end
        default: state <= FR_HUNT;
      endcase
    end
  end

  AST_LOCK_NEEDS_CONFIRM: assert property (@(posedge clk) disable iff (rst)
    (state == FR_SYNC && $past(state) != FR_SYNC) |->
      ($past(state) == FR_PRESYNC && $past(fa_hit)));  // R2

  AST_PRESYNC_MISS_HUNT: assert property (@(posedge clk) disable iff (rst)
    (state == FR_HUNT && $past(state) == FR_PRESYNC) |-> !$past(fa_hit));  // R3

  AST_LOSS_AFTER_LIMIT: assert property (@(posedge clk) disable iff (rst)
    (state == FR_HUNT && $past(state) == FR_SYNC) |->
      ($past(miss) == MISS_TOP && !$past(fa_hit)));  // R4

  AST_COL_STEP: assert property (@(posedge clk) disable iff (rst)
    (state != FR_HUNT && $past(state) != FR_HUNT && $past(col) != COL_LAST)
      |-> col == $past(col) + 1'b1);  // R5

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
    col <= COL_LAST);  // R5

endmodule

// File: rtl/rsf_descramble.sv
module rsf_descramble (
  input  logic       clk,
  input  logic       rst,
  input  logic       enable,
  input  logic       row_zero,
  input  logic [7:0] din,
  output logic [7:0] dout
);
  localparam logic [6:0] SEED = 7'h7F;

  logic [6:0] lfsr;
  logic [6:0] lfsr_adv;
  logic [7:0] key;

  // eight serial steps of x^7+x^6+1, first key bit lands in key[7]
  always_comb begin
    lfsr_adv = lfsr;
    key      = '0;
    for (int i = 7; i >= 0; i--) begin
      key[i]   = lfsr_adv[6];
      lfsr_adv = {lfsr_adv[5:0], lfsr_adv[6] ^ lfsr_adv[5]};
    end
  end

  // row 0 keeps the generator parked at the seed
  always_ff @(posedge clk) begin
    if (rst) lfsr <= SEED;
    else     lfsr <= row_zero ? SEED : lfsr_adv;
  end

  assign dout = (enable && !row_zero) ? (din ^ key) : din;

  AST_SEED_AFTER_ROW0: assert property (@(posedge clk) disable iff (rst)
    ($past(row_zero) && !row_zero) |-> key == 8'hFE);  // R6

endmodule

// File: rtl/rsf_b1_check.sv
module rsf_b1_check
  import rsf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       in_frame,
  input  logic       frame_first,
  input  logic       frame_last,
  input  logic       b1_slot,
  input  logic [7:0] line_byte,
  input  logic [7:0] clear_byte,
  output logic       chk,
  output logic [3:0] bits,
  output logic       blk_err
);
  logic [7:0] acc;
  logic [7:0] prev_bip;
  logic       clean;
  logic       prev_ok;
  logic [7:0] diff;

  assign diff = prev_bip ^ clear_byte;

  // running parity over line bytes, restarted at every frame origin
  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= '0;
      prev_bip <= '0;
      clean    <= 1'b0;
      prev_ok  <= 1'b0;
    end else begin
      acc <= frame_first ? line_byte : (acc ^ line_byte);
      if (frame_first)    clean <= in_frame;
      else if (!in_frame) clean <= 1'b0;
      if (frame_last) begin
        prev_bip <= acc ^ line_byte;
        prev_ok  <= clean && in_frame;
      end else if (!in_frame) begin
        prev_ok <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      chk     <= 1'b0;
      bits    <= '0;
      blk_err <= 1'b0;
    end else begin
      chk     <= 1'b0;
      blk_err <= 1'b0;
      if (b1_slot && in_frame && prev_ok) begin
        chk     <= 1'b1;
        bits    <= ones8(diff);
        blk_err <= |diff;
      end
    end
  end

  AST_BITS_BOUND: assert property (@(posedge clk) disable iff (rst)
    chk |-> bits <= 4'd8);  // R7

  AST_BLK_WITH_CHK: assert property (@(posedge clk) disable iff (rst)
    blk_err |-> (chk && bits != 4'd0));  // R8

  AST_CHK_NEEDS_LOCK: assert property (@(posedge clk) disable iff (rst)
    chk |-> $past(in_frame));  // R9

endmodule

// File: rtl/rs_sink_framer.sv
module rs_sink_framer
  import rsf_pkg::*;
#(
  parameter int unsigned NCH         = 1,
  parameter int unsigned ROWS        = 9,
  parameter int unsigned COLS_PER_CH = 270,
  parameter int unsigned MISS_LIMIT  = 4,
  localparam int unsigned COLS       = COLS_PER_CH * NCH,
  localparam int unsigned ROW_W      = $clog2(ROWS),
  localparam int unsigned COL_W      = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       rx_byte,
  output logic             frm_locked,
  output logic             frm_sof,
  output logic [ROW_W-1:0] frm_row,
  output logic [COL_W-1:0] frm_col,
  output logic [7:0]       frm_data,
  output logic             b1_chk,
  output logic [3:0]       b1_bits,
  output logic             b1_blk_err
);
  localparam int unsigned PAT_HALF = 3;
  localparam int unsigned FA_COL   = 3 * NCH + PAT_HALF - 1;
  localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);
  localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);

  fr_state_t        state;
  logic [ROW_W-1:0] row;
  logic [COL_W-1:0] col;
  logic             fa_hit;
  logic [7:0]       clear_byte;
  logic             row_zero;
  logic             in_frame;

  assign row_zero = (row == '0);
  assign in_frame = (state == FR_SYNC);

  rsf_fa_detect #(.PAT_HALF(PAT_HALF)) u_det (
    .clk (clk),
    .rst (rst),
    .din (rx_byte),
    .hit (fa_hit)
  );

  rsf_align #(
    .ROWS       (ROWS),
    .COLS       (COLS),
    .FA_COL     (FA_COL),
    .MISS_LIMIT (MISS_LIMIT)
  ) u_align (
    .clk    (clk),
    .rst    (rst),
    .fa_hit (fa_hit),
    .state  (state),
    .row    (row),
    .col    (col)
  );

  rsf_descramble u_dscr (
    .clk      (clk),
    .rst      (rst),
    .enable   (state != FR_HUNT),
    .row_zero (row_zero),
    .din      (rx_byte),
    .dout     (clear_byte)
  );

  rsf_b1_check u_b1 (
    .clk         (clk),
    .rst         (rst),
    .in_frame    (in_frame),
    .frame_first (row_zero && col == '0),
    .frame_last  (row == ROW_LAST && col == COL_LAST),
    .b1_slot     (row == ROW_W'(1) && col == '0),
    .line_byte   (rx_byte),
    .clear_byte  (clear_byte),
    .chk         (b1_chk),
    .bits        (b1_bits),
    .blk_err     (b1_blk_err)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      frm_data <= '0;
      frm_row  <= '0;
      frm_col  <= '0;
      frm_sof  <= 1'b0;
    end else begin
      frm_data <= clear_byte;
      frm_row  <= row;
      frm_col  <= col;
      frm_sof  <= in_frame && row_zero && (col == '0);
    end
  end

  assign frm_locked = in_frame;

  AST_ROW0_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (frm_locked && frm_row == '0 && $past(frm_locked)) |-> frm_data == $past(rx_byte));  // R6

  AST_SOF_THEN_COL1: assert property (@(posedge clk) disable iff (rst)
    (frm_sof && frm_locked) |=> frm_col == COL_W'(1));  // R5

endmodule

// File: tb/sim_rs_sink_framer.sv
module sim_rs_sink_framer;
  localparam int ROWS = 9;
  localparam int COLS = 270;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] rx_byte = '0;
  logic       frm_locked, frm_sof, b1_chk, b1_blk_err;
  logic [3:0] frm_row;
  logic [8:0] frm_col;
  logic [7:0] frm_data;
  logic [3:0] b1_bits;

  int n_checks = 0, n_err = 0;
  int n_chk = 0, n_blk = 0, n_sof = 0, dat_err = 0, pos_err = 0;
  int last_bits = 0;
  bit mon_en = 1'b0;
  logic [7:0] tx_bip = '0;

  always #5 clk = ~clk;

  rs_sink_framer u0 (
    .clk(clk), .rst(rst), .rx_byte(rx_byte),
    .frm_locked(frm_locked), .frm_sof(frm_sof), .frm_row(frm_row),
    .frm_col(frm_col), .frm_data(frm_data), .b1_chk(b1_chk),
    .b1_bits(b1_bits), .b1_blk_err(b1_blk_err)
  );

  function automatic logic [7:0] plain(input int r, input int c);
    if (r == 0) return (c < 3) ? 8'hF6 : (c < 6) ? 8'h28 : 8'h00;
    return 8'((r * 37 + c * 11 + 5) & 255);
  endfunction

  // key byte and next generator state for x^7+x^6+1, MSB first
  function automatic logic [14:0] keystep(input logic [6:0] s);
    logic [7:0] k;
    for (int i = 7; i >= 0; i--) begin
      k[i] = s[6];
      s = {s[5:0], s[6] ^ s[5]};
    end
    return {s, k};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  // output monitor, samples away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (b1_chk) begin
        n_chk++;
        last_bits = int'(b1_bits);
        if (b1_blk_err) n_blk++;
      end
      if (frm_sof) n_sof++;
      if (mon_en && frm_locked) begin
        if (frm_sof != (frm_row == 0 && frm_col == 0)) pos_err++;
        if (!(frm_row == 1 && frm_col == 0) &&
            frm_data != plain(int'(frm_row), int'(frm_col))) dat_err++;
      end
    end
  end

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    rx_byte = b;
  endtask

  // one frame; err_mask is a line error on byte err_idx, outside the parity
  task automatic send_frame(input bit bad_fa, input int err_idx, input logic [7:0] err_mask);
    logic [7:0]  pl, sc, acc;
    logic [6:0]  s;
    logic [14:0] ks;
    acc = '0;
    s = 7'h7F;
    for (int r = 0; r < ROWS; r++) begin
      for (int c = 0; c < COLS; c++) begin
        pl = plain(r, c);
        if (r == 0 && c < 3 && bad_fa) pl = 8'h00;
        if (r == 1 && c == 0) pl = tx_bip;
        if (r == 0) begin
          sc = pl;
          s = 7'h7F;
        end else begin
          ks = keystep(s);
          sc = pl ^ ks[7:0];
          s = ks[14:8];
        end
        acc = acc ^ sc;
        send_byte((r * COLS + c == err_idx) ? (sc ^ err_mask) : sc);
      end
    end
    tx_bip = acc;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    chk(frm_locked == 1'b0, "R1 locked after reset", int'(frm_locked), 0);
    chk(frm_sof == 1'b0 && b1_chk == 1'b0, "R1 strobes after reset", int'(frm_sof | b1_chk), 0);
    chk(b1_blk_err == 1'b0, "R1 block error after reset", int'(b1_blk_err), 0);
    rst = 1'b0;
  endtask

  task automatic t_acquire();
    int c0, s0;
    mon_en = 1'b1;
    send_frame(0, -1, 8'h00);
    chk(frm_locked == 1'b0, "R2 one pattern is not lock", int'(frm_locked), 0);
    send_frame(0, -1, 8'h00);
    chk(frm_locked == 1'b1, "R2 lock after second pattern", int'(frm_locked), 1);
    c0 = n_chk; s0 = n_sof;
    send_frame(0, -1, 8'h00);
    chk(n_chk == c0, "R9 no check in first frame after lock", n_chk - c0, 0);
    send_frame(0, -1, 8'h00);
    chk(n_chk == c0 + 1, "R7 check in next frame", n_chk - c0, 1);
    chk(last_bits == 0, "R7 clean frame count", last_bits, 0);
    chk(n_sof == s0 + 2, "R5 sof per frame", n_sof - s0, 2);
    chk(pos_err == 0, "R5 sof at origin", pos_err, 0);
    chk(dat_err == 0, "R6 descrambled payload", dat_err, 0);
  endtask

  task automatic t_parity();
    send_frame(0, COLS, 8'h05);
    chk(last_bits == 2, "R7 error on parity byte", last_bits, 2);
    chk(n_blk == 1, "R8 errored block pulse", n_blk, 1);
    send_frame(0, -1, 8'h00);
    chk(last_bits == 2, "R7 prior frame parity taken on line bytes", last_bits, 2);
    send_frame(0, 5 * COLS + 100, 8'h07);
    chk(last_bits == 0, "R7 payload error not in own frame", last_bits, 0);
    chk(n_blk == 2, "R8 no pulse when clean", n_blk, 2);
    send_frame(0, -1, 8'h00);
    chk(last_bits == 3, "R7 payload error in next frame", last_bits, 3);
    send_frame(0, COLS, 8'hFF);
    chk(last_bits == 8, "R7 all bits wrong", last_bits, 8);
    send_frame(0, -1, 8'h00);
    send_frame(0, -1, 8'h00);
    chk(last_bits == 0 && n_blk == 5, "R8 pulses match non-zero counts", n_blk, 5);
    chk(dat_err == 1, "R6 single payload line error visible", dat_err, 1);
  endtask

  task automatic t_loss();
    int c0;
    mon_en = 1'b0;
    repeat (3) send_frame(1, -1, 8'h00);
    chk(frm_locked == 1'b1, "R4 three misses keep lock", int'(frm_locked), 1);
    send_frame(0, -1, 8'h00);
    repeat (3) send_frame(1, -1, 8'h00);
    chk(frm_locked == 1'b1, "R4 good frame clears miss count", int'(frm_locked), 1);
    c0 = n_chk;
    send_frame(1, -1, 8'h00);
    chk(frm_locked == 1'b0, "R4 fourth miss drops lock", int'(frm_locked), 0);
    send_frame(0, -1, 8'h00);
    chk(frm_locked == 1'b0, "R2 hunt hit is tentative", int'(frm_locked), 0);
    send_frame(1, -1, 8'h00);
    chk(frm_locked == 1'b0, "R3 tentative miss", int'(frm_locked), 0);
    send_frame(0, -1, 8'h00);
    chk(frm_locked == 1'b0, "R3 hunting restarted", int'(frm_locked), 0);
    send_frame(0, -1, 8'h00);
    chk(frm_locked == 1'b1, "R2 relock after two hits", int'(frm_locked), 1);
    send_frame(0, -1, 8'h00);
    chk(n_chk == c0, "R9 no checks out of lock or right after", n_chk - c0, 0);
    send_frame(0, -1, 8'h00);
    chk(n_chk == c0 + 1 && last_bits == 0, "R9 checks resume", n_chk - c0, 1);
  endtask

  task automatic t_shift();
    int d0, s0;
    repeat (777) send_byte(8'h55);
    repeat (8) send_frame(0, -1, 8'h00);
    chk(frm_locked == 1'b1, "R2 lock at shifted phase", int'(frm_locked), 1);
    d0 = dat_err; s0 = n_sof;
    mon_en = 1'b1;
    repeat (2) send_frame(0, -1, 8'h00);
    chk(dat_err == d0 && pos_err == 0, "R5 positions at new phase", dat_err - d0, 0);
    chk(n_sof == s0 + 2, "R5 sof at new phase", n_sof - s0, 2);
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    t_reset();
    t_acquire();
    t_parity();
    t_loss();
    t_shift();
    finish_run();
  end

endmodule